// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This block paces the retries of a contended atomic read-modify-write. Each time the requester's compare-and-swap is rejected, it pulses a failure input. The block answers with a single wait request to an external pause unit. The request carries the current backoff interval converted to clock cycles. The block then drops its ready flag until the pause unit reports that the wait is over.

Each accepted failure doubles the interval used for the following failure. Doubling stops once the interval has passed a fixed ceiling. A success pulse returns the interval to its starting value of one.

Each backoff unit stands for 128 cycles. The whole wait is handed to the pause unit as one amount, not as a series of short fixed waits. The pause unit itself, the atomic operation and any arbitration between requesters lie outside this block.

Top module: `backoff_retry_ctrl`

## Requirements
- R1: After reset, the interval output is 1, the wait amount is 0, the wait-start strobe is low and retry-ready is high.
- R2: A failure pulse that arrives while retry-ready is high is accepted, unless a success pulse arrives in the same cycle. In the cycle after an accepted failure, the wait-start strobe is high and retry-ready is low.
- R3: On an accepted failure, an interval that is at most 4096 (signed comparison) is doubled. An interval of exactly 4096 becomes 8192.
- R4: On an accepted failure, an interval greater than 4096 (signed comparison) is held unchanged. From reset, repeated failures therefore settle at 8192.
- R5: With the strobe, the wait amount equals the interval in force when the failure was accepted, shifted left by 7 bits (interval times 128). It is issued as one request and holds its value until the next request.
- R6: Retry-ready stays low until the pause-done input is seen while a wait is pending. Retry-ready is high again in the cycle after that.
- R7: A failure pulse that arrives while retry-ready is low has no effect. No strobe follows and the interval does not change.
- R8: A success pulse sets the interval to 1 in the next cycle, in any state. A failure pulse in the same cycle as a success pulse is dropped.
- R9: The wait-start strobe is high for exactly one cycle per accepted failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attempt_fail_i | input | 1 | One-cycle pulse: atomic attempt was rejected |
| attempt_ok_i | input | 1 | One-cycle pulse: atomic attempt succeeded |
| pause_done_i | input | 1 | Pause unit reports the requested wait has elapsed |
| backoff_o | output | 16 | Current backoff interval in units |
| wait_amt_o | output | 23 | Wait amount in cycles (interval shifted left by 7) |
| wait_start_o | output | 1 | One-cycle strobe: issue wait_amt_o to the pause unit |
| retry_ready_o | output | 1 | High when the requester may retry |

## Verification
The bench walks the interval from 1 up through 4096 and then past it. A design that used greater-or-equal at the ceiling would stop at 4096 instead of reaching 8192, and a design that kept doubling would wrap the register. It sends failures in the middle of a wait; a design that accepted them would emit a second strobe and skip an interval step. It also sends success together with failure, and success during a wait. A design with the wrong priority would start a wait, or would keep a stale interval. Pause-done is given after several different delays, so a design that freed retry-ready early, or captured the wait amount after the update, would give the wrong amount or the wrong ready timing.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

  localparam int DEF_BACKOFF_W   = 16;
  localparam int DEF_SCALE_SHIFT = 7;
  localparam int DEF_CEILING     = 4096;
  localparam int DEF_INIT        = 1;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;

  // Interval to use after one more rejected attempt: double while not above ceiling.
  function automatic int next_interval(input int cur, input int ceil_v);
    if (cur > ceil_v) return cur;
    return cur * 2;
  endfunction

endpackage

// File: rtl/backoff_interval.sv
module backoff_interval #(
  parameter int BACKOFF_W = 16,
  parameter int CEILING   = 4096,
  parameter int INIT      = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restore_i,
  input  logic                 advance_i,
  output logic [BACKOFF_W-1:0] value_o
);
  import backoff_pkg::*;

  logic [BACKOFF_W-1:0] value_q;
  logic [BACKOFF_W-1:0] value_next;
  logic [BACKOFF_W-1:0] grown;

  always_comb begin
    grown = BACKOFF_W'(next_interval(int'($signed(value_q)), CEILING));
  end

  always_comb begin
    value_next = value_q;
    if (restore_i) begin
      value_next = BACKOFF_W'(INIT);
    end else if (advance_i) begin
      value_next = grown;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= BACKOFF_W'(INIT);
    end else begin
      value_q <= value_next;
    end
  end

  assign value_o = value_q;

endmodule

// File: rtl/wait_request.sv
module wait_request #(
  parameter int BACKOFF_W   = 16,
  parameter int SCALE_SHIFT = 7,
  localparam int WAIT_W     = BACKOFF_W + SCALE_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_i,
  input  logic [BACKOFF_W-1:0] interval_i,
  output logic [WAIT_W-1:0]    amount_o,
  output logic                 start_o
);

  function automatic logic [WAIT_W-1:0] scale_to_cycles(input logic [BACKOFF_W-1:0] units);
    return WAIT_W'(units) << SCALE_SHIFT;
  endfunction

  logic [WAIT_W-1:0] amount_q;
  logic              start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amount_q <= '0;
      start_q  <= 1'b0;
    end else begin
      start_q <= issue_i;
      if (issue_i) begin
        amount_q <= scale_to_cycles(interval_i);
      end
    end
  end

  assign amount_o = amount_q;
  assign start_o  = start_q;

endmodule

// File: rtl/retry_sequencer.sv
module retry_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_i,
  input  logic ok_i,
  input  logic done_i,
  output logic accept_o,
  output logic ready_o
);
  import backoff_pkg::*;

  seq_state_t state_q;
  seq_state_t state_next;

  always_comb begin
    accept_o   = (state_q == SEQ_IDLE) && fail_i && !ok_i;
    state_next = state_q;
    case (state_q)
      SEQ_IDLE: if (accept_o) state_next = SEQ_WAIT;
      SEQ_WAIT: if (done_i)   state_next = SEQ_IDLE;
      default:                state_next = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_next;
    end
  end

  assign ready_o = (state_q == SEQ_IDLE);

endmodule

// File: rtl/backoff_retry_ctrl.sv
module backoff_retry_ctrl #(
  parameter int BACKOFF_W   = backoff_pkg::DEF_BACKOFF_W,
  parameter int SCALE_SHIFT = backoff_pkg::DEF_SCALE_SHIFT,
  parameter int CEILING     = backoff_pkg::DEF_CEILING,
  parameter int INIT        = backoff_pkg::DEF_INIT,
  localparam int WAIT_W     = BACKOFF_W + SCALE_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 attempt_fail_i,
  input  logic                 attempt_ok_i,
  input  logic                 pause_done_i,
  output logic [BACKOFF_W-1:0] backoff_o,
  output logic [WAIT_W-1:0]    wait_amt_o,
  output logic                 wait_start_o,
  output logic                 retry_ready_o
);

  // Named internal events, visible to the bound checker.
  logic fail_accepted;
  logic success_seen;

  assign success_seen = attempt_ok_i;

  retry_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fail_i   (attempt_fail_i),
    .ok_i     (attempt_ok_i),
    .done_i   (pause_done_i),
    .accept_o (fail_accepted),
    .ready_o  (retry_ready_o)
  );

  backoff_interval #(
    .BACKOFF_W (BACKOFF_W),
    .CEILING   (CEILING),
    .INIT      (INIT)
  ) u_interval (
    .clk       (clk),
    .rst_n     (rst_n),
    .restore_i (success_seen),
    .advance_i (fail_accepted),
    .value_o   (backoff_o)
  );

  wait_request #(
    .BACKOFF_W   (BACKOFF_W),
    .SCALE_SHIFT (SCALE_SHIFT)
  ) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (fail_accepted),
    .interval_i (backoff_o),
    .amount_o   (wait_amt_o),
    .start_o    (wait_start_o)
  );

endmodule

// File: rtl/backoff_retry_chk.sv
module backoff_retry_chk #(
  parameter int BACKOFF_W   = 16,
  parameter int SCALE_SHIFT = 7,
  parameter int CEILING     = 4096,
  parameter int INIT        = 1,
  localparam int WAIT_W     = BACKOFF_W + SCALE_SHIFT
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 attempt_fail_i,
  input logic                 attempt_ok_i,
  input logic                 pause_done_i,
  input logic [BACKOFF_W-1:0] backoff_o,
  input logic [WAIT_W-1:0]    wait_amt_o,
  input logic                 wait_start_o,
  input logic                 retry_ready_o,
  input logic                 fail_accepted
);

  AST_ACCEPT_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fail_accepted |-> (retry_ready_o && attempt_fail_i && !attempt_ok_i)); // R2

  AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fail_accepted |=> (wait_start_o && !retry_ready_o)); // R2

  AST_DOUBLE_BELOW_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_accepted && ($signed(backoff_o) <= CEILING))
      |=> (backoff_o == BACKOFF_W'($past(backoff_o) << 1))); // R3

  AST_HOLD_ABOVE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_accepted && ($signed(backoff_o) > CEILING)) |=> $stable(backoff_o)); // R4

  AST_AMT_SCALED: assert property (@(posedge clk) disable iff (!rst_n)
    wait_start_o |-> (wait_amt_o == (WAIT_W'($past(backoff_o)) << SCALE_SHIFT))); // R5

  AST_READY_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!retry_ready_o && !pause_done_i) |=> !retry_ready_o); // R6

  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!retry_ready_o && pause_done_i) |=> retry_ready_o); // R6

  AST_FAIL_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!retry_ready_o && attempt_fail_i) |=> !wait_start_o); // R7

  AST_SUCCESS_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_ok_i |=> (backoff_o == BACKOFF_W'(INIT))); // R8

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wait_start_o |=> !wait_start_o); // R9

endmodule

bind backoff_retry_ctrl backoff_retry_chk #(
  .BACKOFF_W   (BACKOFF_W),
  .SCALE_SHIFT (SCALE_SHIFT),
  .CEILING     (CEILING),
  .INIT        (INIT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .attempt_fail_i (attempt_fail_i),
  .attempt_ok_i   (attempt_ok_i),
  .pause_done_i   (pause_done_i),
  .backoff_o      (backoff_o),
  .wait_amt_o     (wait_amt_o),
  .wait_start_o   (wait_start_o),
  .retry_ready_o  (retry_ready_o),
  .fail_accepted  (fail_accepted)
);

// File: tb/test_backoff_retry_ctrl.sv
`timescale 1ns/1ps
module test_backoff_retry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fail = 1'b0;
  logic        ok = 1'b0;
  logic        done = 1'b0;
  logic [15:0] backoff;
  logic [22:0] amt;
  logic        strobe;
  logic        ready;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  int m_backoff = 1;
  int m_amt     = 0;
  bit m_strobe  = 0;
  bit m_busy    = 0;

  always #2 clk = ~clk; // 250 MHz

  backoff_retry_ctrl i_backoff_retry_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .attempt_fail_i (fail),
    .attempt_ok_i   (ok),
    .pause_done_i   (done),
    .backoff_o      (backoff),
    .wait_amt_o     (amt),
    .wait_start_o   (strobe),
    .retry_ready_o  (ready)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Reference model: advances on each rising edge from the inputs held across it.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_backoff = 1; m_amt = 0; m_strobe = 0; m_busy = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_strobe = 0;
      if (was_busy && done) m_busy = 0;
      if (ok) begin
        m_backoff = 1;
      end else if (fail && !was_busy) begin
        m_amt    = m_backoff * 128;
        m_strobe = 1;
        m_busy   = 1;
        if (m_backoff <= 4096) m_backoff = m_backoff * 2;
      end
    end
  end

  // Every-cycle comparison, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 interval", int'(backoff), m_backoff);
      check("R5 amount", int'(amt), m_amt);
      check("R2 strobe", int'(strobe), int'(m_strobe));
      check("R6 ready", int'(ready), int'(!m_busy));
    end
  end

  // One rejected attempt followed by a pause of 'delay' cycles.
  task automatic fail_and_wait(input int delay);
    @(negedge clk); fail = 1'b1;
    @(negedge clk); fail = 1'b0;
    check("R9 strobe high", int'(strobe), 1);
    @(negedge clk);
    check("R9 strobe one cycle", int'(strobe), 0);
    repeat (delay) @(negedge clk);
    check("R6 ready low while pending", int'(ready), 0);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R6 ready after done", int'(ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 interval", int'(backoff), 1);
    check("R1 amount", int'(amt), 0);
    check("R1 strobe", int'(strobe), 0);
    check("R1 ready", int'(ready), 1);

    // Doubling walk up to and past the ceiling
    exp_v = 1;
    for (int i = 0; i < 16; i++) begin
      fail_and_wait(i % 4);
      check("R5 amount of request", int'(amt), exp_v * 128);
      if (exp_v <= 4096) exp_v = exp_v * 2;
      check("R3 doubled", int'(backoff), exp_v);
    end
    check("R4 held above ceiling", int'(backoff), 8192);
    fail_and_wait(2);
    check("R4 still held", int'(backoff), 8192);
    check("R5 top amount", int'(amt), 8192 * 128);

    // Success restores the interval
    @(negedge clk); ok = 1'b1;
    @(negedge clk); ok = 1'b0;
    check("R8 restore", int'(backoff), 1);

    // Failure during a pending wait is ignored
    fail_and_wait(0);
    @(negedge clk); fail = 1'b1;
    @(negedge clk); fail = 1'b0;
    repeat (2) @(negedge clk);
    fail = 1'b1;
    @(negedge clk); fail = 1'b0;
    check("R7 no strobe", int'(strobe), 0);
    check("R7 interval kept", int'(backoff), 4);
    check("R7 amount kept", int'(amt), 2 * 128);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R6 ready back", int'(ready), 1);

    // Success with a simultaneous failure: failure dropped
    @(negedge clk); ok = 1'b1; fail = 1'b1;
    @(negedge clk); ok = 1'b0; fail = 1'b0;
    check("R8 no strobe", int'(strobe), 0);
    check("R8 interval", int'(backoff), 1);
    check("R8 ready", int'(ready), 1);

    // Success during a pending wait
    fail_and_wait(1);
    @(negedge clk); fail = 1'b1;
    @(negedge clk); fail = 1'b0;
    ok = 1'b1;
    @(negedge clk); ok = 1'b0;
    check("R8 restore while waiting", int'(backoff), 1);
    check("R6 still waiting", int'(ready), 0);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R6 ready after done", int'(ready), 1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule